// File: doc/BRIEF.md
# Registered Zero Counter

This unit counts zero bits at one end of a 64-bit operand and returns the count in a registered 64-bit result. Two mode inputs choose among four flavours: the width select decides whether the whole operand or only its low 32-bit word is examined, and the direction select decides whether zeros are counted from the most significant end (leading) or from the least significant end (trailing).

The result register loads on every clock edge from whatever operand and modes are present, so a new request can be issued every cycle. Its answer appears one cycle after the request. The count occupies the low seven bits of the result and the remaining bits stay zero. An operand with no ones in the examined range reports the full width of that range.

Top module: `zcnt_top`

## Requirements
- R1: With `trail_i`=0 and `word_i`=0, a single one at bit 63-i yields a result of i for every i in 0..63.
- R2: With `trail_i`=1 and `word_i`=0, a single one at bit i yields a result of i for every i in 0..63.
- R3: With `word_i`=0 and an all-zero operand, the result is 64 (0x40) in both directions.
- R4: With `word_i`=1 and `trail_i`=0, a single one at bit 31-i yields i for i in 0..31, whatever bits 63..32 hold.
- R5: With `word_i`=1 and `trail_i`=1, a single one at bit i yields i for i in 0..31, whatever bits 63..32 hold.
- R6: With `word_i`=1, a zero low word yields 32 (0x20) in both directions, so ones in bits 63..32 are ignored.
- R7: The result reflects the operand and modes sampled at the previous rising clock edge, and it updates on every edge without an enable.
- R8: Result bits 63..7 are always zero.
- R9: While `rst_ni` is low the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | 64 | Value whose zeros are counted |
| word_i | input | 1 | 1: examine bits 31..0 only; 0: all 64 bits |
| trail_i | input | 1 | 0: leading count; 1: trailing count |
| result_o | output | 64 | Registered zero count, zero-extended |

## Verification
Two functions meet in one cycle when word mode and the trailing direction act together on an operand whose upper word is not zero: the bit reversal moves the upper word's ones into positions that the word mask must then discard. The bench provokes this by sweeping single ones through the low word while filling bits 63..32 with a fixed nonzero pattern, and by presenting a zero low word under a full upper word, judging each result against an arithmetic scan of only the low 32 bits. Requests change every cycle, so each check also confirms that the previous request does not leak into the next.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
endpackage

// File: rtl/zcnt_bitrev.sv
module zcnt_bitrev #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign out_o[g] = in_i[W-1-g];
  end
endmodule

// File: rtl/zcnt_align.sv
// Puts the examined range at the top of the vector; a sentinel one below a
// word-mode range caps the count at HALF_W.
module zcnt_align #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned HALF_W = 32
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              word_i,
  input  logic              trail_i,
  output logic [DATA_W-1:0] aligned_o
);
  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] src;

  zcnt_bitrev #(.W(DATA_W)) i_rev (.in_i(operand_i), .out_o(rev));

  always_comb begin
    if (trail_i)     src = rev;
    else if (word_i) src = operand_i << HALF_W;
    else             src = operand_i;
    if (word_i) begin
      aligned_o = '0;
      aligned_o[DATA_W-1 -: HALF_W] = src[DATA_W-1 -: HALF_W];
      aligned_o[DATA_W-HALF_W-1]    = 1'b1;
    end else begin
      aligned_o = src;
    end
  end
endmodule

// File: rtl/zcnt_lead_enc.sv
module zcnt_lead_enc #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 7
) (
  input  logic [DATA_W-1:0] vec_i,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(DATA_W);
    for (int k = 0; k < DATA_W; k++) begin
      if (vec_i[k]) cnt_o = CNT_W'(DATA_W - 1 - k);
    end
  end
endmodule

// File: rtl/zcnt_top.sv
module zcnt_top
  import zcnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              word_i,
  input  logic              trail_i,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] aligned;
  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              seen_q;

  zcnt_align #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_align (
    .operand_i(operand_i), .word_i(word_i), .trail_i(trail_i), .aligned_o(aligned)
  );

  zcnt_lead_enc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_enc (
    .vec_i(aligned), .cnt_o(cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= 1'b1;
    end
  end

  assign result_o = {{(DATA_W-CNT_W){1'b0}}, cnt_q};

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[DATA_W-1:CNT_W] == '0);

  assert_full_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(operand_i) == '0 && !$past(word_i) |-> result_o == DATA_W);

  assert_word_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(operand_i[HALF_W-1:0]) == '0 && $past(word_i) |-> result_o == HALF_W);

  assert_word_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(word_i) |-> result_o <= HALF_W);

  assert_msb_lead_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(operand_i[DATA_W-1]) && !$past(word_i) && !$past(trail_i)
    |-> result_o == 0);

  assert_lsb_trail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(operand_i[0]) && $past(trail_i) |-> result_o == 0);
endmodule

// File: tb/test_zcnt_top.sv
module test_zcnt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] operand = '0;
  logic        word = 1'b0;
  logic        trail = 1'b0;
  logic [63:0] result;
  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  zcnt_top i_zcnt_top (
    .clk_i(clk), .rst_ni(rst_n), .operand_i(operand),
    .word_i(word), .trail_i(trail), .result_o(result)
  );

  function automatic int ref_cnt(logic [63:0] op, bit w, bit t);
    int n = w ? 32 : 64;
    int c = 0;
    if (!t) begin
      for (int k = n - 1; k >= 0; k--) begin
        if (op[k]) break;
        c++;
      end
    end else begin
      for (int k = 0; k < n; k++) begin
        if (op[k]) break;
        c++;
      end
    end
    return c;
  endfunction

  task automatic check(string tag, logic [63:0] exp);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, result, exp);
    end
  endtask

  // entered at a falling edge; result checked at the next falling edge
  task automatic step(string tag, logic [63:0] op, bit w, bit t, int exp);
    operand = op; word = w; trail = t;
    @(negedge clk);
    check(tag, 64'(exp));
  endtask

  initial begin
    #800000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    operand = 64'h0000_0100_0000_0000;
    repeat (3) @(negedge clk);
    check("R9 reset", 64'd0);
    rst_n = 1'b1;

    // R1/R2: every single-bit position, full width
    for (int i = 0; i < 64; i++) step("R1 lead64", 64'd1 << (63 - i), 1'b0, 1'b0, i);
    for (int i = 0; i < 64; i++) step("R2 trail64", 64'd1 << i, 1'b0, 1'b1, i);
    // R4/R5: word mode, upper word garbage must be ignored
    for (int i = 0; i < 32; i++) step("R4 lead32", (64'd1 << (31 - i)) | 64'hA5C3_0F01_0000_0000, 1'b1, 1'b0, i);
    for (int i = 0; i < 32; i++) step("R5 trail32", (64'd1 << i) | 64'h8000_0000_0000_0000, 1'b1, 1'b1, i);
    // word mode, one above the low word only: saturates
    for (int i = 32; i < 64; i++) step("R6 upper-only lead", 64'd1 << i, 1'b1, 1'b0, 32);
    for (int i = 32; i < 64; i++) step("R6 upper-only trail", 64'd1 << i, 1'b1, 1'b1, 32);
    // all-zero corners
    step("R3 zero lead64", 64'd0, 1'b0, 1'b0, 64);
    step("R3 zero trail64", 64'd0, 1'b0, 1'b1, 64);
    step("R6 zero lead32", 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 32);
    step("R6 zero trail32", 64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1, 32);
    step("R8 upper bits", 64'd0, 1'b0, 1'b1, 64);
    // R7: multi-bit patterns, flavour changes every cycle
    begin
      logic [63:0] v = 64'h1234_5678_9ABC_DEF1;
      for (int j = 0; j < 200; j++) begin
        bit w = j[0];
        bit t = j[1];
        v = {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
        step("R7 pattern", v >> (j % 61), w, t, ref_cnt(v >> (j % 61), w, t));
      end
    end
    // R7: held inputs keep result stable over several edges
    operand = 64'h0000_0000_0001_0000; word = 1'b0; trail = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R7 hold", 64'd16);
    end
    // R9: async reset clears a nonzero result
    rst_n = 1'b0;
    #1;
    check("R9 async", 64'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule